// File: doc/BRIEF.md
# Line Alarm Persistence Filter with Event Flags

This block sits behind a receive-side defect detector on a framed digital line. It takes three raw defect indicators and a 1 ms timebase strobe: a far-end (yellow) indicator, a loss-of-frame (red) indicator and an all-ones (AIS) indicator. Each indicator is debounced over time. An alarm becomes active only after its indicator has stayed asserted for a set number of consecutive milliseconds. It becomes inactive only after the indicator has stayed deasserted for a separate, usually much longer, number of milliseconds. The red and AIS alarms also have a shortened clearing time, selected by one control bit.

Every change of an alarm's state, in either direction, latches a sticky event flag for that alarm. The interrupt output is a level. It is high while any event flag whose enable bit is set remains high. A four-word register port gives access to the alarm states, the event flags (cleared by writing 1), the enables and the fast-clear control. All durations are parameters counted in strobes of `ms_tick`. The defaults are 425/425 ms for yellow, 2550/16600 ms (fast 120 ms) for red, and 1500/16800 ms (fast 180 ms) for AIS.

Top module: `line_alarm_monitor`

## Requirements
- R1: The yellow alarm becomes active on the clock edge that carries the YEL_SET_MS-th consecutive tick with `raw_yellow` high. It becomes inactive on the edge that carries the YEL_CLR_MS-th consecutive tick with `raw_yellow` low. The fast-clear bit does not change the yellow timing.
- R2: The red alarm becomes active after RED_SET_MS consecutive ticks with `raw_red` high. It becomes inactive after RED_CLR_MS consecutive ticks with `raw_red` low, or after RED_FAST_MS ticks when fast-clear is 1.
- R3: The AIS alarm becomes active after AIS_SET_MS consecutive ticks with `raw_ais` high. It becomes inactive after AIS_CLR_MS consecutive ticks with `raw_ais` low, or after AIS_FAST_MS ticks when fast-clear is 1.
- R4: In any cycle where the raw indicator equals the current alarm state, the elapsed count restarts from zero. A run that is interrupted before reaching its limit therefore never changes the state.
- R5: Time advances only in cycles where `ms_tick` is 1. With `ms_tick` held at 0, no alarm state changes.
- R6: Reading address 0 returns the alarm states: bit 0 yellow, bit 1 red, bit 2 AIS, and bits 7:3 zero.
- R7: Each change of an alarm state, 0 to 1 or 1 to 0, sets that alarm's event flag. The flag then stays set. Address 1 reads the flags with the same bit positions as R6.
- R8: Writing address 1 clears each event flag whose data bit is 1. Bits written as 0 leave their flags unchanged. When a state change occurs on the same edge as the clear, the flag stays set.
- R9: `irq` is active high and equals the OR, over the three alarms, of the event flag ANDed with its enable bit.
- R10: Address 2 holds the enable bits, bits 2:0 in the R6 order. Address 3 bit 0 holds the fast-clear bit. Both addresses read back the value last written, with the unused bits reading 0.
- R11: Reset clears the alarm states, event flags, enables, fast-clear and all elapsed counts. After reset, an indicator needs the full declare time again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ms_tick | input | 1 | One-cycle strobe once per millisecond |
| raw_yellow | input | 1 | Raw far-end defect indicator |
| raw_red | input | 1 | Raw loss-of-frame indicator |
| raw_ais | input | 1 | Raw all-ones indicator |
| reg_addr | input | 2 | Register address: 0 state, 1 events, 2 enables, 3 control |
| reg_wr | input | 1 | Write strobe, sampled on the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The bench uses short durations and a tick on every cycle. For each alarm it sweeps the asserted-run length from one tick up to one past the declare limit. This separates off-by-one errors on the declare side. Each declared alarm is then held off and probed one tick before and exactly at its clear limit, both with and without fast-clear. This shows whether the fast mode reaches red and AIS only. Broken runs, a gated tick and a reset in the middle of a count distinguish true consecutive counting from plain accumulation. Clear writes that coincide with a state change, partial clear masks and toggled enables probe the event priority and the interrupt gating.

// File: rtl/lam_pkg.sv
package lam_pkg;

  localparam int NUM_ALARMS = 3;
  localparam int REG_W      = 8;

  localparam int IDX_YEL = 0;
  localparam int IDX_RED = 1;
  localparam int IDX_AIS = 2;

  typedef enum logic [1:0] {
    ADDR_STATE  = 2'd0,
    ADDR_EVENT  = 2'd1,
    ADDR_ENABLE = 2'd2,
    ADDR_CTRL   = 2'd3
  } lam_addr_e;

  function automatic int lam_max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/lam_rst_sync.sv
module lam_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/lam_integrator.sv
module lam_integrator #(
  parameter int SET_TICKS  = 425,
  parameter int CLR_TICKS  = 425,
  parameter int FAST_TICKS = 425,
  parameter bit HAS_FAST   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw,
  input  logic fast_en,
  output logic state,
  output logic flip
);
  localparam int MAXT = lam_pkg::lam_max3(SET_TICKS, CLR_TICKS, FAST_TICKS);
  localparam int CW   = $clog2(MAXT + 1);

  logic          st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] limit;
  logic [CW:0]   cnt_inc;
  logic          use_fast;
  logic          upd_ce;

  // Fast clearing only exists for the alarms built with it.
  generate
    if (HAS_FAST) begin : g_fast
      assign use_fast = fast_en;
    end else begin : g_nofast
      assign use_fast = 1'b0;
    end
  endgenerate

  // The limit depends on the direction of the pending change.
  always_comb begin
    if (!st_q)         limit = CW'(SET_TICKS);
    else if (use_fast) limit = CW'(FAST_TICKS);
    else               limit = CW'(CLR_TICKS);
  end

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};
    st_d    = st_q;
    cnt_d   = cnt_q;
    flip    = 1'b0;
    if (raw == st_q) begin
      cnt_d = '0;
    end else if (tick) begin
      if (cnt_inc >= {1'b0, limit}) begin
        st_d  = ~st_q;
        cnt_d = '0;
        flip  = 1'b1;
      end else begin
        cnt_d = cnt_inc[CW-1:0];
      end
    end
  end

  assign upd_ce = tick | (raw == st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= 1'b0;
      cnt_q <= '0;
    end else if (upd_ce) begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/lam_csr.sv
module lam_csr
  import lam_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            addr,
  input  logic                  wr,
  input  logic [REG_W-1:0]      wdata,
  input  logic [NUM_ALARMS-1:0] status,
  input  logic [NUM_ALARMS-1:0] flip,
  output logic [NUM_ALARMS-1:0] events,
  output logic [NUM_ALARMS-1:0] enables,
  output logic                  fast_clear,
  output logic [REG_W-1:0]      rdata,
  output logic                  irq
);
  localparam int PAD = REG_W - NUM_ALARMS;

  logic [NUM_ALARMS-1:0] ev_q, ev_d, en_q, en_d, clr_mask;
  logic                  fc_q, fc_d;
  logic                  wr_ev, wr_en, wr_fc;
  logic                  ev_ce;

  always_comb begin
    wr_ev    = wr && (lam_addr_e'(addr) == ADDR_EVENT);
    wr_en    = wr && (lam_addr_e'(addr) == ADDR_ENABLE);
    wr_fc    = wr && (lam_addr_e'(addr) == ADDR_CTRL);
    clr_mask = wr_ev ? wdata[NUM_ALARMS-1:0] : '0;
    // A new change wins over a clear on the same edge.
    ev_d     = (ev_q & ~clr_mask) | flip;
    ev_ce    = wr_ev | (|flip);
    en_d     = wdata[NUM_ALARMS-1:0];
    fc_d     = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q <= '0;
      en_q <= '0;
      fc_q <= 1'b0;
    end else begin
      if (ev_ce) ev_q <= ev_d;
      if (wr_en) en_q <= en_d;
      if (wr_fc) fc_q <= fc_d;
    end
  end

  always_comb begin
    unique case (lam_addr_e'(addr))
      ADDR_STATE:  rdata = {{PAD{1'b0}}, status};
      ADDR_EVENT:  rdata = {{PAD{1'b0}}, ev_q};
      ADDR_ENABLE: rdata = {{PAD{1'b0}}, en_q};
      default:     rdata = {{(REG_W-1){1'b0}}, fc_q};
    endcase
  end

  assign irq        = |(ev_q & en_q);
  assign events     = ev_q;
  assign enables    = en_q;
  assign fast_clear = fc_q;
endmodule

// File: rtl/line_alarm_monitor.sv
module line_alarm_monitor
  import lam_pkg::*;
#(
  parameter int YEL_SET_MS  = 425,
  parameter int YEL_CLR_MS  = 425,
  parameter int RED_SET_MS  = 2550,
  parameter int RED_CLR_MS  = 16600,
  parameter int RED_FAST_MS = 120,
  parameter int AIS_SET_MS  = 1500,
  parameter int AIS_CLR_MS  = 16800,
  parameter int AIS_FAST_MS = 180
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       raw_yellow,
  input  logic       raw_red,
  input  logic       raw_ais,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);
  logic                  rst_sn;
  logic [NUM_ALARMS-1:0] raw_vec;
  logic [NUM_ALARMS-1:0] status_vec;
  logic [NUM_ALARMS-1:0] flip_vec;
  logic [NUM_ALARMS-1:0] event_vec;
  logic [NUM_ALARMS-1:0] enable_vec;
  logic                  fast_clear;

  assign raw_vec = {raw_ais, raw_red, raw_yellow};

  lam_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sn)
  );

  for (genvar g = 0; g < NUM_ALARMS; g++) begin : g_alarm
    localparam int SET_T  = (g == IDX_YEL) ? YEL_SET_MS :
                            (g == IDX_RED) ? RED_SET_MS : AIS_SET_MS;
    localparam int CLR_T  = (g == IDX_YEL) ? YEL_CLR_MS :
                            (g == IDX_RED) ? RED_CLR_MS : AIS_CLR_MS;
    localparam int FAST_T = (g == IDX_YEL) ? YEL_CLR_MS :
                            (g == IDX_RED) ? RED_FAST_MS : AIS_FAST_MS;
    localparam bit HAS_F  = (g != IDX_YEL);

    lam_integrator #(
      .SET_TICKS  (SET_T),
      .CLR_TICKS  (CLR_T),
      .FAST_TICKS (FAST_T),
      .HAS_FAST   (HAS_F)
    ) u_integ (
      .clk     (clk),
      .rst_n   (rst_sn),
      .tick    (ms_tick),
      .raw     (raw_vec[g]),
      .fast_en (fast_clear),
      .state   (status_vec[g]),
      .flip    (flip_vec[g])
    );
  end

  lam_csr u_csr (
    .clk        (clk),
    .rst_n      (rst_sn),
    .addr       (reg_addr),
    .wr         (reg_wr),
    .wdata      (reg_wdata),
    .status     (status_vec),
    .flip       (flip_vec),
    .events     (event_vec),
    .enables    (enable_vec),
    .fast_clear (fast_clear),
    .rdata      (reg_rdata),
    .irq        (irq)
  );
endmodule

// File: rtl/lam_checker.sv
module lam_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       ms_tick,
  input logic [2:0] raw,
  input logic [2:0] status,
  input logic [2:0] events,
  input logic [2:0] enables,
  input logic       irq
);
  assert_yel_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> $past(raw[0]));
  assert_yel_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[0]) |-> !$past(raw[0]));
  assert_red_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> $past(raw[1]));
  assert_red_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[1]) |-> !$past(raw[1]));
  assert_ais_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[2]) |-> $past(raw[2]));
  assert_ais_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[2]) |-> !$past(raw[2]));
  assert_change_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status) |-> $past(ms_tick));
  assert_event_on_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((status ^ $past(status)) & ~events) == 3'b000);
  assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (enables == 3'b000) |-> !irq);
  assert_irq_needs_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (events == 3'b000) |-> !irq);
endmodule

bind line_alarm_monitor lam_checker u_lam_checker (
  .clk     (clk),
  .rst_n   (rst_sn),
  .ms_tick (ms_tick),
  .raw     (raw_vec),
  .status  (status_vec),
  .events  (event_vec),
  .enables (enable_vec),
  .irq     (irq)
);

// File: tb/test_line_alarm_monitor.sv
`timescale 1ns/1ps
module test_line_alarm_monitor;
  localparam int YS = 3, YC = 4;
  localparam int RS = 5, RC = 9, RF = 2;
  localparam int AS = 6, AC = 10, AF = 3;

  logic       clk;
  logic       rst_n;
  logic       tick;
  logic [2:0] raw;
  logic [1:0] addr;
  logic       we;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       irq;

  int n_chk  = 0;
  int n_fail = 0;

  line_alarm_monitor #(
    .YEL_SET_MS(YS), .YEL_CLR_MS(YC),
    .RED_SET_MS(RS), .RED_CLR_MS(RC), .RED_FAST_MS(RF),
    .AIS_SET_MS(AS), .AIS_CLR_MS(AC), .AIS_FAST_MS(AF)
  ) i_line_alarm_monitor (
    .clk        (clk),
    .rst_n      (rst_n),
    .ms_tick    (tick),
    .raw_yellow (raw[0]),
    .raw_red    (raw[1]),
    .raw_ais    (raw[2]),
    .reg_addr   (addr),
    .reg_wr     (we),
    .reg_wdata  (wdata),
    .reg_rdata  (rdata),
    .irq        (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr  = a;
    wdata = d;
    we    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we    = 1'b0;
  endtask

  task automatic st_bit(input int idx, input string req, input logic exp);
    logic [7:0] v;
    rd(2'd0, v);
    chk(req, 8'(v[idx]), 8'(exp));
  endtask

  // Sweep asserted-run length 1..D+1, then probe the clear boundary.
  task automatic sweep(input int idx, input int d, input int c, input string req);
    logic [7:0] v;
    for (int len = 1; len <= d + 1; len++) begin
      raw[idx] = 1'b1;
      run(len);
      st_bit(idx, req, len >= d);
      raw[idx] = 1'b0;
      if (len >= d) begin
        run(c - 1);
        st_bit(idx, req, 1'b1);
        run(1);
        st_bit(idx, req, 1'b0);
        rd(2'd1, v);
        chk("R7 event after clear", 8'(v[idx]), 8'd1);
      end else begin
        run(1);
      end
      wr(2'd1, 8'h07);
    end
  endtask

  // Broken runs must not accumulate.
  task automatic gap(input int idx, input int d, input int c, input string req);
    raw[idx] = 1'b1; run(d - 1);
    raw[idx] = 1'b0; run(1);
    raw[idx] = 1'b1; run(d - 1);
    st_bit(idx, req, 1'b0);
    run(1);
    st_bit(idx, req, 1'b1);
    raw[idx] = 1'b0; run(c - 1);
    raw[idx] = 1'b1; run(1);
    raw[idx] = 1'b0; run(c - 1);
    st_bit(idx, req, 1'b1);
    run(1);
    st_bit(idx, req, 1'b0);
    wr(2'd1, 8'h07);
  endtask

  task automatic fast(input int idx, input int d, input int c, input string req);
    raw[idx] = 1'b1; run(d);
    st_bit(idx, req, 1'b1);
    raw[idx] = 1'b0; run(c - 1);
    st_bit(idx, req, 1'b1);
    run(1);
    st_bit(idx, req, 1'b0);
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; tick = 1'b1; raw = 3'b000;
    addr = 2'd0; we = 1'b0; wdata = 8'h00;
    run(3);
    rst_n = 1'b1;
    run(3);

    // R11 reset state, R6 readout
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R11 reset register", v, 8'h00);
    end
    chk("R11 reset irq", 8'(irq), 8'd0);

    // R1/R2/R3 sweeps, R4 broken runs
    sweep(0, YS, YC, "R1 yellow timing");
    sweep(1, RS, RC, "R2 red timing");
    sweep(2, AS, AC, "R3 AIS timing");
    gap(0, YS, YC, "R4 yellow restart");
    gap(1, RS, RC, "R4 red restart");
    gap(2, AS, AC, "R4 AIS restart");

    // R6 bit positions with all alarms active
    raw = 3'b111; run(AS);
    rd(2'd0, v);
    chk("R6 state word", v, 8'h07);
    raw = 3'b000; run(AC);
    rd(2'd0, v);
    chk("R6 state word cleared", v, 8'h00);
    wr(2'd1, 8'h07);

    // R10 control and enable readback, fast-clear modes
    wr(2'd3, 8'hFF);
    rd(2'd3, v);
    chk("R10 control readback", v, 8'h01);
    wr(2'd2, 8'hFD);
    rd(2'd2, v);
    chk("R10 enable readback", v, 8'h05);
    wr(2'd2, 8'h00);
    fast(1, RS, RF, "R2 red fast clear");
    fast(2, AS, AF, "R3 AIS fast clear");
    fast(0, YS, YC, "R1 yellow ignores fast clear");
    wr(2'd3, 8'h00);
    fast(1, RS, RC, "R2 red normal clear");
    wr(2'd1, 8'h07);

    // R5 tick gating
    tick = 1'b0; raw[0] = 1'b1;
    run(20);
    st_bit(0, "R5 no tick no change", 1'b0);
    tick = 1'b1; run(YS - 1);
    st_bit(0, "R5 count from first tick", 1'b0);
    run(1);
    st_bit(0, "R5 count from first tick", 1'b1);

    // R7/R8/R9 events and interrupt
    rd(2'd1, v);
    chk("R7 event on declare", v, 8'h01);
    chk("R9 irq masked", 8'(irq), 8'd0);
    wr(2'd2, 8'h01);
    chk("R9 irq enabled", 8'(irq), 8'd1);
    wr(2'd1, 8'h00);
    rd(2'd1, v);
    chk("R8 zero write keeps flag", v, 8'h01);
    wr(2'd1, 8'h06);
    rd(2'd1, v);
    chk("R8 other bits keep flag", v, 8'h01);
    wr(2'd1, 8'h01);
    rd(2'd1, v);
    chk("R8 write one clears", v, 8'h00);
    chk("R9 irq after clear", 8'(irq), 8'd0);
    raw[0] = 1'b0; run(YC - 1);
    wr(2'd1, 8'h01);
    rd(2'd1, v);
    chk("R8 change beats clear", v, 8'h01);
    st_bit(0, "R8 change beats clear state", 1'b0);
    chk("R9 irq on clear event", 8'(irq), 8'd1);
    wr(2'd2, 8'h06);
    chk("R9 irq other enables", 8'(irq), 8'd0);
    raw[1] = 1'b1; run(RS);
    chk("R9 irq red enabled", 8'(irq), 8'd1);
    raw[1] = 1'b0; run(RC);
    wr(2'd1, 8'h07);
    chk("R9 irq after clear all", 8'(irq), 8'd0);

    // R11 reset mid-count clears timers and registers
    wr(2'd2, 8'h07);
    wr(2'd3, 8'h01);
    raw[0] = 1'b1; run(YS - 1);
    rst_n = 1'b0; run(2);
    rst_n = 1'b1; run(2);
    run(YS - 1);
    st_bit(0, "R11 timer restarted", 1'b0);
    run(1);
    st_bit(0, "R11 timer restarted", 1'b1);
    rd(2'd2, v);
    chk("R11 enables cleared", v, 8'h00);
    rd(2'd3, v);
    chk("R11 fast clear cleared", v, 8'h00);
    raw[0] = 1'b0; run(YC);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule